// File: doc/BRIEF.md
# Amplifier Control Two-Wire Slave

This block is the serial control port of a four-channel audio power amplifier. A host talks to it over a two-wire bus (I2C) at up to 400 kHz. A write carries two instruction bytes. The block decodes them into static control lines: standby release, diagnostic enable, offset-check enable, a 16 dB gain select per speaker group, an unmute per group, a clip-detector threshold select, a line-driver diagnostic range, and a high-efficiency select for each side.

A read returns four status bytes. These are built from the fault flags that the diagnostic logic presents for each channel, together with a few global status bits. All four bytes are frozen at the moment the read address is accepted, so the host always sees one coherent picture. That picture comes from the diagnostic cycle that ran before the read. Once a read has delivered all four bytes and the bus is stopped, the block emits a one-cycle strobe that tells the diagnostic logic to start its cycles again.

SCL and SDA are oversampled by the system clock. SDA is driven open-drain: the block only ever pulls the line low.

Top module: `amp_i2c_ctrl`

## Requirements
- R1: After reset, every control output is 0, `sda_oe` is 0 and `diag_rearm` is 0.
- R2: The 7-bit device address is 1101100, so the address byte is 0xD8 for a write and 0xD9 for a read. A matching address is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the block leaves SDA released and every output unchanged until the next START.
- R3: In a write, the first data byte is instruction byte A and the second is instruction byte B. The block acknowledges each of them. Each byte takes effect as soon as its eighth bit is sampled, so byte A is visible on the outputs before byte B is sent.
- R4: Instruction byte A decodes as follows: bit 6 is diagnostic enable, bit 5 is offset enable, bit 4 selects front gain 16 dB, bit 3 selects rear gain 16 dB, bit 2 unmutes the front group, bit 1 unmutes the rear group, and bit 0 selects the 10 % clip threshold. Bit 7 is ignored.
- R5: Instruction byte B decodes as follows: bit 4 releases standby, bit 3 selects the line-driver diagnostic range, bit 1 selects high efficiency on the right side, and bit 0 selects it on the left side. Bits 7, 6, 5 and 2 are ignored.
- R6: In a write, every byte after the second gets no acknowledge and changes no output.
- R7: A read returns four bytes, most significant bit first, in this order:
  - byte 1 is {thermal_warn, diag_done, 0, LF flags};
  - byte 2 is {offs_active, 0, 0, LR flags};
  - byte 3 is {standby released, diagnostic enable, 0, RF flags};
  - byte 4 is {0, 0, 0, RR flags}.

  Each set of channel flags is 5 bits: {permanent-mode, short load, open/offset, short to supply, short to ground}. In `ch_flags`, LF sits at [4:0], LR at [9:5], RF at [14:10] and RR at [19:15].
- R8: SDA driven by the block changes only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.
- R9: The four read bytes are captured when the read address is accepted. Changes on the flag inputs during the read do not alter the bytes being sent.
- R10: `diag_rearm` pulses high for exactly one clock on a STOP that follows a read in which the acknowledge clock of the fourth byte was completed. A read that ends earlier produces no pulse.
- R11: When the host does not acknowledge a read byte, the block releases SDA and sends nothing more until the next START, so further clocked bytes read as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | 1 = pull SDA low |
| ch_flags | input | 20 | Per-channel fault flags, LF/LR/RF/RR, 5 bits each |
| thermal_warn | input | 1 | Thermal warning status |
| diag_done | input | 1 | Diagnostic cycle terminated |
| offs_active | input | 1 | Offset detection running |
| stby_off | output | 1 | Standby released (amplifier working) |
| diag_en | output | 1 | Diagnostics enabled |
| offs_en | output | 1 | Offset detection enabled |
| front_g16 | output | 1 | Front group gain 16 dB |
| rear_g16 | output | 1 | Rear group gain 16 dB |
| front_unmute | output | 1 | Front group unmuted |
| rear_unmute | output | 1 | Rear group unmuted |
| clip_10pct | output | 1 | Clip detector at 10 % threshold |
| line_drv_diag | output | 1 | Line-driver diagnostic range |
| he_right | output | 1 | Right side high-efficiency mode |
| he_left | output | 1 | Left side high-efficiency mode |
| diag_rearm | output | 1 | One-cycle strobe after a complete read |

## Verification
The bench changes the fault flags just after the first read byte. A design that samples the flags live instead of holding a snapshot would return the new values in bytes 2 to 4.

The bench sends a third write byte and a foreign address. Both must go unacknowledged and leave the controls alone; a byte counter that wraps, or a loose address compare, would overwrite the instruction registers.

The bench also ends one read early with a host NACK. A design that fires `diag_rearm` on any read, or that keeps driving data after the NACK, is caught by the strobe count and by the 0xFF byte that must follow.

Finally, the bench drives all flags and status inputs to 1 and checks that the unused bit positions still read 0. It also watches for SDA moving while SCL is high, which a design would do if it updated its data on the rising clock edge.

// File: rtl/ampctl_pkg.sv
package ampctl_pkg;

  localparam int N_CH    = 4;
  localparam int CH_W    = 5;
  localparam int FLAGS_W = N_CH * CH_W;
  localparam int SNAP_W  = N_CH * 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_WR, S_RD, S_RACK, S_SKIP
  } bus_st_t;

  typedef struct packed {
    logic stby_off;
    logic diag_en;
    logic offs_en;
    logic front_g16;
    logic rear_g16;
    logic front_unm;
    logic rear_unm;
    logic clip10;
    logic line_drv;
    logic he_right;
    logic he_left;
  } ctrl_t;

  // Instruction bytes -> control lines
  function automatic ctrl_t decode_ctrl(input logic [7:0] ia, input logic [7:0] ib);
    ctrl_t c;
    c.diag_en   = ia[6];
    c.offs_en   = ia[5];
    c.front_g16 = ia[4];
    c.rear_g16  = ia[3];
    c.front_unm = ia[2];
    c.rear_unm  = ia[1];
    c.clip10    = ia[0];
    c.stby_off  = ib[4];
    c.line_drv  = ib[3];
    c.he_right  = ib[1];
    c.he_left   = ib[0];
    return c;
  endfunction

  // Status bytes, first byte in the top octet
  function automatic logic [SNAP_W-1:0] pack_diag(
    input logic [FLAGS_W-1:0] f,
    input logic thermal, input logic done, input logic offs,
    input logic stby, input logic diag);
    logic [7:0] b1, b2, b3, b4;
    b1 = {thermal, done, 1'b0, f[4:0]};
    b2 = {offs, 2'b00, f[9:5]};
    b3 = {stby, diag, 1'b0, f[14:10]};
    b4 = {3'b000, f[19:15]};
    return {b1, b2, b3, b4};
  endfunction

  // Select byte i (0 = first sent) of a snapshot
  function automatic logic [7:0] pick_byte(input logic [SNAP_W-1:0] w, input logic [1:0] i);
    logic [SNAP_W-1:0] t;
    t = w << {i, 3'b000};
    return t[SNAP_W-1 -: 8];
  endfunction

endpackage

// File: rtl/amp_i2c_sync.sv
module amp_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] now_v;
  logic [NLINE-1:0] old_v;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw[g]};
    end
    assign now_v[g] = pipe[STAGES-1];
    assign old_v[g] = pipe[STAGES];
  end

  assign scl_s    = now_v[0];
  assign sda_s    = now_v[1];
  assign scl_rise = now_v[0] & ~old_v[0];
  assign scl_fall = ~now_v[0] & old_v[0];
  assign start_ev = now_v[0] & old_v[0] & old_v[1] & ~now_v[1];
  assign stop_ev  = now_v[0] & old_v[0] & ~old_v[1] & now_v[1];

endmodule

// File: rtl/amp_i2c_engine.sv
module amp_i2c_engine
  import ampctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [SNAP_W-1:0] tx_snap,
  output logic              sda_oe,
  output logic              snap_load,
  output logic              ia_stb,
  output logic              ib_stb,
  output logic [7:0]        rx_data,
  output logic              rd_busy,
  output logic              rearm
);
  bus_st_t    st;
  logic [3:0] bit_cnt;
  logic [7:0] sh;
  logic [2:0] byte_idx;
  logic       ack_en, rw, addr_done, rd_full, m_ack;

  logic       rx_phase, rx_last, addr_match;
  logic [7:0] nxt_byte;

  assign rx_phase   = (st == S_ADDR) || (st == S_WR);
  assign rx_last    = rx_phase && scl_rise && (bit_cnt == 4'd7);
  assign rx_data    = {sh[6:0], sda_s};
  assign addr_match = (rx_data[7:1] == DEV_ADDR);
  assign snap_load  = rx_last && (st == S_ADDR) && addr_match && sda_s;
  assign ia_stb     = rx_last && (st == S_WR) && (byte_idx == 3'd0);
  assign ib_stb     = rx_last && (st == S_WR) && (byte_idx == 3'd1);
  assign rd_busy    = (st == S_RD) || (st == S_RACK);
  assign nxt_byte   = pick_byte(tx_snap, byte_idx[1:0] + 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bit_cnt <= '0; sh <= '0; byte_idx <= '0;
      ack_en <= 1'b0; rw <= 1'b0; addr_done <= 1'b0; rd_full <= 1'b0;
      m_ack <= 1'b0; sda_oe <= 1'b0; rearm <= 1'b0;
    end else begin
      rearm <= 1'b0;
      if (start_ev) begin
        st <= S_ADDR; bit_cnt <= '0; byte_idx <= '0;
        addr_done <= 1'b0; rd_full <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        rearm <= rd_full; rd_full <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              sh      <= rx_data;
              bit_cnt <= bit_cnt + 4'd1;
              if (bit_cnt == 4'd7) begin
                if (st == S_ADDR) begin
                  ack_en <= addr_match;
                  rw     <= sda_s;
                end else begin
                  ack_en <= (byte_idx < 3'd2);
                end
              end
            end
            if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (ack_en) begin st <= S_ACK; sda_oe <= 1'b1; end
              else        st <= S_SKIP;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (!addr_done) begin
                addr_done <= 1'b1;
                if (rw) begin
                  st     <= S_RD;
                  sh     <= pick_byte(tx_snap, 2'd0);
                  sda_oe <= ~tx_snap[SNAP_W-1];
                end else begin
                  st     <= S_WR;
                  sda_oe <= 1'b0;
                end
              end else begin
                byte_idx <= byte_idx + 3'd1;
                st       <= S_WR;
                sda_oe   <= 1'b0;
              end
            end
          end
          S_RD: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                st <= S_RACK; sda_oe <= 1'b0;
              end else begin
                sh      <= {sh[6:0], 1'b0};
                sda_oe  <= ~sh[6];
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
              if (byte_idx == 3'd3) rd_full <= 1'b1;
            end
            if (scl_fall) begin
              if (m_ack && byte_idx < 3'd3) begin
                byte_idx <= byte_idx + 3'd1;
                st       <= S_RD;
                sh       <= nxt_byte;
                sda_oe   <= ~nxt_byte[7];
                bit_cnt  <= '0;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the line is pulled low only while acknowledging or sending data
  a_r2_oe_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ACK || st == S_RD));

  // R8: the driven data never moves while SCL is high
  a_r8_sda_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10: re-arm strobe lasts a single clock
  a_r10_rearm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !rearm);

  // R11: after a host NACK the block stays silent
  a_r11_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);

endmodule

// File: rtl/amp_i2c_regs.sv
module amp_i2c_regs
  import ampctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ia_stb,
  input  logic               ib_stb,
  input  logic [7:0]         rx_data,
  input  logic               snap_load,
  input  logic               rd_busy,
  input  logic [FLAGS_W-1:0] ch_flags,
  input  logic               thermal_warn,
  input  logic               diag_done,
  input  logic               offs_active,
  output ctrl_t              ctrl,
  output logic [SNAP_W-1:0]  snap
);
  logic [7:0] ia_q, ib_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia_q <= '0;
      ib_q <= '0;
      snap <= '0;
    end else begin
      if (ia_stb)    ia_q <= rx_data;
      if (ib_stb)    ib_q <= rx_data;
      if (snap_load) snap <= pack_diag(ch_flags, thermal_warn, diag_done,
                                       offs_active, ctrl.stby_off, ctrl.diag_en);
    end
  end

  assign ctrl = decode_ctrl(ia_q, ib_q);

  // R9: the snapshot is frozen while bytes are being sent
  a_r9_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(snap));

  // R6: controls move only on an accepted instruction byte
  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ia_stb || ib_stb) |=> $stable(ctrl));

endmodule

// File: rtl/amp_i2c_ctrl.sv
module amp_i2c_ctrl
  import ampctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [FLAGS_W-1:0] ch_flags,
  input  logic               thermal_warn,
  input  logic               diag_done,
  input  logic               offs_active,
  output logic               stby_off,
  output logic               diag_en,
  output logic               offs_en,
  output logic               front_g16,
  output logic               rear_g16,
  output logic               front_unmute,
  output logic               rear_unmute,
  output logic               clip_10pct,
  output logic               line_drv_diag,
  output logic               he_right,
  output logic               he_left,
  output logic               diag_rearm
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic snap_load, ia_stb, ib_stb, rd_busy;
  logic [7:0] rx_data;
  logic [SNAP_W-1:0] snap;
  ctrl_t ctrl;

  amp_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  amp_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .tx_snap(snap), .sda_oe(sda_oe),
    .snap_load(snap_load), .ia_stb(ia_stb), .ib_stb(ib_stb),
    .rx_data(rx_data), .rd_busy(rd_busy), .rearm(diag_rearm));

  amp_i2c_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ia_stb(ia_stb), .ib_stb(ib_stb),
    .rx_data(rx_data), .snap_load(snap_load), .rd_busy(rd_busy),
    .ch_flags(ch_flags), .thermal_warn(thermal_warn), .diag_done(diag_done),
    .offs_active(offs_active), .ctrl(ctrl), .snap(snap));

  assign stby_off      = ctrl.stby_off;
  assign diag_en       = ctrl.diag_en;
  assign offs_en       = ctrl.offs_en;
  assign front_g16     = ctrl.front_g16;
  assign rear_g16      = ctrl.rear_g16;
  assign front_unmute  = ctrl.front_unm;
  assign rear_unmute   = ctrl.rear_unm;
  assign clip_10pct    = ctrl.clip10;
  assign line_drv_diag = ctrl.line_drv;
  assign he_right      = ctrl.he_right;
  assign he_left       = ctrl.he_left;

  // R10: a strobe is always preceded by a STOP seen on the bus
  a_r10_rearm_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    diag_rearm |-> $past(stop_ev));

endmodule

// File: tb/sim_amp_i2c_ctrl.sv
module sim_amp_i2c_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [19:0] ch_flags = '0;
  logic thermal_warn = 1'b0, diag_done = 1'b0, offs_active = 1'b0;
  logic stby_off, diag_en, offs_en, front_g16, rear_g16, front_unmute, rear_unmute;
  logic clip_10pct, line_drv_diag, he_right, he_left, diag_rearm;

  int checks = 0, failures = 0, rearm_cnt = 0, r8_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] e_ia = '0, e_ib = '0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  amp_i2c_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .ch_flags(ch_flags), .thermal_warn(thermal_warn), .diag_done(diag_done),
    .offs_active(offs_active), .stby_off(stby_off), .diag_en(diag_en),
    .offs_en(offs_en), .front_g16(front_g16), .rear_g16(rear_g16),
    .front_unmute(front_unmute), .rear_unmute(rear_unmute), .clip_10pct(clip_10pct),
    .line_drv_diag(line_drv_diag), .he_right(he_right), .he_left(he_left),
    .diag_rearm(diag_rearm));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (diag_rearm) rearm_cnt++;
    if (rst_n && sda_oe !== prev_oe && m_scl) r8_viol++;
    prev_oe = sda_oe;
  end

  // scoreboard monitor
  always @(posedge clk) begin
    if (act_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
      end else begin
        e = 8'hxx; t = "R7 extra byte";
      end
      check(t, {24'd0, a}, {24'd0, e});
    end
  end

  task automatic q();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); ack = ~sda_bus; q(); m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; q(); m_scl = 1'b1; q(); b[i] = sda_bus; q(); m_scl = 1'b0; q();
    end
    m_sda = ~host_ack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q(); m_sda = 1'b1;
  endtask

  function automatic logic [10:0] ctrl_act();
    return {stby_off, diag_en, offs_en, front_g16, rear_g16, front_unmute,
            rear_unmute, clip_10pct, line_drv_diag, he_right, he_left};
  endfunction

  function automatic logic [10:0] ctrl_exp();
    return {e_ib[4], e_ia[6], e_ia[5], e_ia[4], e_ia[3], e_ia[2], e_ia[1], e_ia[0],
            e_ib[3], e_ib[1], e_ib[0]};
  endfunction

  task automatic push_expected(input string t);
    exp_q.push_back({thermal_warn, diag_done, 1'b0, ch_flags[4:0]});   tag_q.push_back({t, " byte1"});
    exp_q.push_back({offs_active, 2'b00, ch_flags[9:5]});               tag_q.push_back({t, " byte2"});
    exp_q.push_back({e_ib[4], e_ia[6], 1'b0, ch_flags[14:10]});         tag_q.push_back({t, " byte3"});
    exp_q.push_back({3'b000, ch_flags[19:15]});                         tag_q.push_back({t, " byte4"});
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int rc0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    q();
    // R1 reset state
    check("R1 ctrl", {21'd0, ctrl_act()}, 32'd0);
    check("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    check("R1 rearm", rearm_cnt, 0);

    // R2 R3 R4 R5: full write
    i2c_start();
    send_byte(8'hD8, ack); check("R2 write address ack", {31'd0, ack}, 1);
    send_byte(8'h55, ack); check("R3 byte A ack", {31'd0, ack}, 1);
    e_ia = 8'h55;
    check("R3 byte A effective before byte B", {21'd0, ctrl_act()}, {21'd0, ctrl_exp()});
    send_byte(8'h1B, ack); check("R3 byte B ack", {31'd0, ack}, 1);
    e_ib = 8'h1B;
    i2c_stop();
    check("R4 R5 decode 55/1B", {21'd0, ctrl_act()}, {21'd0, ctrl_exp()});

    // R6: third byte refused
    i2c_start();
    send_byte(8'hD8, ack);
    send_byte(8'hAA, ack); e_ia = 8'hAA;
    send_byte(8'h68, ack); e_ib = 8'h68;
    send_byte(8'hFF, ack); check("R6 third byte nack", {31'd0, ack}, 0);
    i2c_stop();
    check("R6 third byte ignored R4 R5 decode AA/68", {21'd0, ctrl_act()}, {21'd0, ctrl_exp()});

    // R2: foreign address
    i2c_start();
    send_byte(8'hDA, ack); check("R2 foreign address nack", {31'd0, ack}, 0);
    send_byte(8'h7F, ack); check("R2 following byte nack", {31'd0, ack}, 0);
    i2c_stop();
    check("R2 outputs unchanged", {21'd0, ctrl_act()}, {21'd0, ctrl_exp()});

    // R7 R9 R10: full read with flags changing mid-transfer
    ch_flags = 20'hA5C3E; thermal_warn = 1'b1; diag_done = 1'b0; offs_active = 1'b1;
    rc0 = rearm_cnt;
    push_expected("R7 R9 read1");
    i2c_start();
    send_byte(8'hD9, ack); check("R2 read address ack", {31'd0, ack}, 1);
    recv_byte(1'b1, b); act_q.push_back(b);
    ch_flags = 20'h5A3C1; thermal_warn = 1'b0; offs_active = 1'b0;
    recv_byte(1'b1, b); act_q.push_back(b);
    recv_byte(1'b1, b); act_q.push_back(b);
    recv_byte(1'b0, b); act_q.push_back(b);
    i2c_stop();
    check("R10 rearm after full read", rearm_cnt - rc0, 1);

    // R7 unused bits zero, status bits reflect controls
    i2c_start();
    send_byte(8'hD8, ack); send_byte(8'h40, ack); send_byte(8'h10, ack);
    e_ia = 8'h40; e_ib = 8'h10;
    i2c_stop();
    ch_flags = '1; thermal_warn = 1'b1; diag_done = 1'b1; offs_active = 1'b1;
    push_expected("R7 read2 all ones");
    i2c_start();
    send_byte(8'hD9, ack);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, b); act_q.push_back(b);
    end
    i2c_stop();
    check("R10 second rearm", rearm_cnt - rc0, 2);

    // R11 R10: host NACK after byte 2
    ch_flags = 20'h0F0F1;
    push_expected("R11 partial read");
    void'(exp_q.pop_back()); void'(tag_q.pop_back());
    void'(exp_q.pop_back()); void'(tag_q.pop_back());
    i2c_start();
    send_byte(8'hD9, ack);
    recv_byte(1'b1, b); act_q.push_back(b);
    recv_byte(1'b0, b); act_q.push_back(b);
    recv_byte(1'b0, b);
    check("R11 released after nack", {24'd0, b}, 32'hFF);
    i2c_stop();
    check("R10 no rearm on partial read", rearm_cnt - rc0, 2);

    q(); q();
    check("R7 scoreboard drained", exp_q.size(), 0);
    check("R8 sda stable while scl high", r8_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule